// File: doc/BRIEF.md
# Configurable Asynchronous Serial Character Receiver

This block recovers serial characters from an asynchronous receive line sampled with a 16x oversampling tick. It takes the same 8-bit line-control byte that programs the matching transmitter. From that byte it uses the character length, whether a parity bit is present, odd or even parity, and forced (mark/space) parity. The receive line first passes through a two-flop synchronizer. A falling edge starts a frame, and the frame is kept only if the line is still low half a bit later. Every later bit is then sampled once, one bit period after the previous sample point.

Each recovered character is loaded into a single holding register together with three status flags: parity error, framing error and break. A one-cycle strobe marks the update. Only the first stop bit is examined. The line-control byte is captured when a start bit is confirmed, so changing it during a frame affects only the next character.

Top module: `serial_char_rx`

## Requirements
- R1: A low level on `rxd`, after the two-stage synchronizer, starts a frame. The frame is accepted only if the synchronized line is still low 8 ticks later. A low pulse shorter than that produces no character.
- R2: `line_ctrl[1:0]` selects the character length: 0 = 5 bits, 1 = 6, 2 = 7, 3 = 8. Bits arrive least significant first and land in `rx_data[0]` upward. Unused upper bits of `rx_data` read 0.
- R3: After start confirmation, each data, parity and stop bit is sampled exactly once, 16 ticks after the previous sample point. Sampling advances only on cycles where `os_tick` is 1.
- R4: With `line_ctrl[3]`=1 and `line_ctrl[5]`=0, one parity bit follows the last data bit. With `line_ctrl[4]`=0 the ones count over data plus parity must be odd; with `line_ctrl[4]`=1 it must be even. Otherwise `parity_err` is set.
- R5: With `line_ctrl[3]`=1 and `line_ctrl[5]`=1, the parity bit must be 0 when `line_ctrl[4]`=1 and 1 when `line_ctrl[4]`=0. Otherwise `parity_err` is set.
- R6: With `line_ctrl[3]`=0 no parity bit is expected and `parity_err` is 0.
- R7: Only the first stop bit is checked. `line_ctrl[2]`, `line_ctrl[6]` and `line_ctrl[7]` have no effect on reception. `frame_err` is 1 exactly when that stop bit is sampled 0.
- R8: `break_det` is 1 exactly when every data bit, the parity bit (if present) and the stop bit of the frame are 0.
- R9: After a framing error, no new start bit is searched for until the synchronized line has returned high.
- R10: `rx_valid` is a one-cycle pulse per character. `rx_data`, `parity_err`, `frame_err` and `break_det` update with that pulse and hold until the next one.
- R11: After reset `rx_valid`, `rx_data`, `parity_err`, `frame_err` and `break_det` are all 0.
- R12: `line_ctrl` is captured at start confirmation. A change during a frame does not alter how that frame is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| os_tick | input | 1 | Oversampling enable, 16 per bit period |
| rxd | input | 1 | Asynchronous serial receive line, idle high |
| line_ctrl | input | 8 | Line-control byte (length, parity enable, even, stick) |
| rx_data | output | 8 | Last received character, zero-filled |
| rx_valid | output | 1 | One-cycle strobe: holding register updated |
| parity_err | output | 1 | Parity check failed for the held character |
| frame_err | output | 1 | First stop bit of the held character was 0 |
| break_det | output | 1 | Held frame was all zeros through the stop bit |

## Verification
The bench sweeps every combination of the low six line-control bits against several data patterns, with correct and deliberately inverted parity. A receiver that picked the wrong length, bit order or parity sense would miscompare on data or parity flag. All-zero frames are sent under every setting to separate a true break from a plain framing error. Odd parity on zero data gives a parity bit of 1, so a design that ignored the parity bit would report a false break. Further tests cover a short start glitch, which a design that skipped the mid-bit confirmation would accept as a character. A long low line after a bad stop bit would make a design that did not wait for the line to return high emit extra characters. A control change mid-frame and a slow, gated tick check the capture point and the tick-only advancement.

// File: rtl/serial_char_rx_pkg.sv
// Shared constants and types for the serial character receiver.
package serial_char_rx_pkg;

    localparam int CHAR_MAX = 8;   // widest character in bits
    localparam int MIN_LEN  = 5;   // length for code 0

    // Decoded line-control settings used while a frame is received
    typedef struct packed {
        logic [1:0] len_code;   // 0..3 -> 5..8 bits
        logic       par_en;     // parity bit present
        logic       par_even;   // even sense / space when stick
        logic       par_stick;  // forced parity value
    } rx_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_HOLD
    } rx_state_t;

endpackage

// File: rtl/rx_sync.sv
// Multi-stage synchronizer for the asynchronous receive line.
// Assumes the line idles high; all stages reset to 1 so no false start
// is seen leaving reset.
module rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer stages
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_lcr_decode.sv
// Decodes the 8-bit line-control byte into the receive settings.
// Stop-bit count and the upper control bits do not affect reception.
module rx_lcr_decode
    import serial_char_rx_pkg::*;
(
    input  logic [7:0] lcr,
    output rx_cfg_t    cfg
);
    logic unused_lcr_bits;

    // Map control fields onto the configuration struct
    always_comb begin
        cfg.len_code  = lcr[1:0];
        cfg.par_en    = lcr[3];
        cfg.par_even  = lcr[4];
        cfg.par_stick = lcr[5];
    end

    assign unused_lcr_bits = ^{lcr[7:6], lcr[2]};
endmodule

// File: rtl/rx_frame_fsm.sv
// Frame sequencer: hunts for a start bit, confirms it at mid-bit, then
// samples data, optional parity and the first stop bit one bit period
// apart. Assumes a synchronized line and an oversampling tick of OSR per bit.
module rx_frame_fsm
    import serial_char_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rxd_s,
    input  rx_cfg_t             cfg_live,
    output rx_cfg_t             cfg_q,
    output logic                frame_done,
    output logic [CHAR_MAX-1:0] data_q,
    output logic                par_q,
    output logic                stop_q
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(CHAR_MAX);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(OSR / 2 - 1);
    localparam logic [CNT_W-1:0] FULL_LAST = CNT_W'(OSR - 1);

    rx_state_t          state;
    logic [CNT_W-1:0]   tick_cnt;
    logic [IDX_W-1:0]   bit_idx;
    logic [IDX_W-1:0]   last_idx;
    logic               at_sample;

    // Index of the final data bit for the captured length
    assign last_idx  = IDX_W'(MIN_LEN - 1) + IDX_W'(cfg_q.len_code);
    // A full bit period has elapsed on this tick
    assign at_sample = os_tick && (tick_cnt == FULL_LAST);

    // Frame state, bit timing and bit capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            tick_cnt   <= '0;
            bit_idx    <= '0;
            data_q     <= '0;
            par_q      <= 1'b0;
            stop_q     <= 1'b1;
            cfg_q      <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (os_tick && !rxd_s) begin
                        state    <= ST_START;
                        tick_cnt <= '0;
                    end
                end
                ST_START: begin
                    if (os_tick) begin
                        if (tick_cnt == HALF_LAST) begin
                            tick_cnt <= '0;
                            if (!rxd_s) begin
                                state   <= ST_DATA;
                                bit_idx <= '0;
                                data_q  <= '0;
                                cfg_q   <= cfg_live;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end else begin
                            tick_cnt <= tick_cnt + 1'b1;
                        end
                    end
                end
                ST_DATA: begin
                    if (at_sample) begin
                        tick_cnt        <= '0;
                        data_q[bit_idx] <= rxd_s;
                        if (bit_idx == last_idx)
                            state <= cfg_q.par_en ? ST_PAR : ST_STOP;
                        else
                            bit_idx <= bit_idx + 1'b1;
                    end else if (os_tick) begin
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
                ST_PAR: begin
                    if (at_sample) begin
                        tick_cnt <= '0;
                        par_q    <= rxd_s;
                        state    <= ST_STOP;
                    end else if (os_tick) begin
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
                ST_STOP: begin
                    if (at_sample) begin
                        tick_cnt   <= '0;
                        stop_q     <= rxd_s;
                        frame_done <= 1'b1;
                        state      <= rxd_s ? ST_IDLE : ST_HOLD;
                    end else if (os_tick) begin
                        tick_cnt <= tick_cnt + 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (rxd_s) state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Timing state only moves on a tick (line-wait state excepted)
    assert_tick_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!os_tick && state != ST_HOLD) |=> ($stable(state) && $stable(tick_cnt)));

    // Entering data phase requires the line low at the confirm point
    assert_start_confirm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DATA && $past(state) == ST_START) |-> $past(!rxd_s));

    // No hunting for a start bit while the line is still low after a bad stop
    assert_wait_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !rxd_s) |=> (state == ST_HOLD));
endmodule

// File: rtl/rx_result_reg.sv
// Evaluates parity, framing and break for a finished frame and loads the
// single holding register. Assumes frame_done is a one-cycle pulse with the
// frame fields stable in that cycle.
module rx_result_reg
    import serial_char_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_done,
    input  rx_cfg_t             cfg_q,
    input  logic [CHAR_MAX-1:0] data_q,
    input  logic                par_q,
    input  logic                stop_q,
    output logic [CHAR_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                parity_err,
    output logic                frame_err,
    output logic                break_det
);
    logic ones_odd;
    logic perr_c;
    logic brk_c;

    // Parity verdict for normal and forced parity
    always_comb begin
        ones_odd = (^data_q) ^ par_q;
        if (!cfg_q.par_en)
            perr_c = 1'b0;
        else if (cfg_q.par_stick)
            perr_c = (par_q == cfg_q.par_even);
        else
            perr_c = (ones_odd == cfg_q.par_even);
    end

    // Break: everything through the first stop bit was low
    assign brk_c = (data_q == '0) && (!cfg_q.par_en || !par_q) && !stop_q;

    // Holding register and status flags, updated once per frame
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
            break_det  <= 1'b0;
        end else begin
            rx_valid <= frame_done;
            if (frame_done) begin
                rx_data    <= data_q;
                parity_err <= perr_c;
                frame_err  <= !stop_q;
                break_det  <= brk_c;
            end
        end
    end

    assert_valid_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_break_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && break_det) |-> (frame_err && rx_data == '0));

    assert_no_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_q.par_en) |-> !parity_err);

    assert_zero_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && cfg_q.len_code == 2'b00) |-> (rx_data[CHAR_MAX-1:MIN_LEN] == '0));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |=> $stable(rx_data));
endmodule

// File: rtl/serial_char_rx.sv
// Top level of the asynchronous serial character receiver: synchronizer,
// control decode, frame sequencer and result holding register.
// Assumes os_tick pulses OSR times per bit period.
module serial_char_rx
    import serial_char_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                os_tick,
    input  logic                rxd,
    input  logic [7:0]          line_ctrl,
    output logic [CHAR_MAX-1:0] rx_data,
    output logic                rx_valid,
    output logic                parity_err,
    output logic                frame_err,
    output logic                break_det
);
    logic                rxd_s;
    rx_cfg_t             cfg_live;
    rx_cfg_t             cfg_q;
    logic                frame_done;
    logic [CHAR_MAX-1:0] data_q;
    logic                par_q;
    logic                stop_q;

    rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rxd),
        .dout (rxd_s)
    );

    rx_lcr_decode u_dec (
        .lcr(line_ctrl),
        .cfg(cfg_live)
    );

    rx_frame_fsm #(.OSR(OSR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .os_tick   (os_tick),
        .rxd_s     (rxd_s),
        .cfg_live  (cfg_live),
        .cfg_q     (cfg_q),
        .frame_done(frame_done),
        .data_q    (data_q),
        .par_q     (par_q),
        .stop_q    (stop_q)
    );

    rx_result_reg u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_done(frame_done),
        .cfg_q     (cfg_q),
        .data_q    (data_q),
        .par_q     (par_q),
        .stop_q    (stop_q),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid),
        .parity_err(parity_err),
        .frame_err (frame_err),
        .break_det (break_det)
    );
endmodule

// File: tb/sim_serial_char_rx.sv
module sim_serial_char_rx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic [7:0] line_ctrl = 8'h00;
    logic [7:0] rx_data;
    logic       rx_valid, parity_err, frame_err, break_det;

    int checks = 0;
    int fails  = 0;
    int tick_div = 1;
    int tick_ph  = 0;
    int valid_cnt = 0;
    logic [7:0] cap_data;
    logic       cap_perr, cap_ferr, cap_brk;

    serial_char_rx u0 (
        .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
        .line_ctrl(line_ctrl), .rx_data(rx_data), .rx_valid(rx_valid),
        .parity_err(parity_err), .frame_err(frame_err), .break_det(break_det)
    );

    always #4 clk = ~clk;   // 125 MHz

    // Tick generator, updated away from the active edge
    always @(negedge clk) begin
        tick_ph = (tick_ph + 1) % tick_div;
        os_tick = (tick_ph == 0);
    end

    // Capture each strobe
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            valid_cnt++;
            cap_data = rx_data;
            cap_perr = parity_err;
            cap_ferr = frame_err;
            cap_brk  = break_det;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            do @(posedge clk); while (!os_tick);
        end
    endtask

    task automatic put_bit(input logic b);
        @(negedge clk);
        rxd = b;
        wait_ticks(16);
    endtask

    // Send one frame; optional control change after the first data bit
    task automatic send_frame(input logic [7:0] lcr, input logic [7:0] data,
                              input bit bad_par, input logic stop_b,
                              input int extra_low, input bit chg, input logic [7:0] lcr2);
        int len;
        logic [7:0] d;
        logic p;
        len = 5 + lcr[1:0];
        d = data & ((8'd1 << len) - 8'd1);
        if (lcr[5]) p = ~lcr[4];
        else        p = lcr[4] ? ^d : ~^d;
        p = p ^ bad_par;
        @(negedge clk);
        line_ctrl = lcr;
        put_bit(1'b0);
        for (int i = 0; i < len; i++) begin
            put_bit(d[i]);
            if (i == 0 && chg) line_ctrl = lcr2;
        end
        if (lcr[3]) put_bit(p);
        put_bit(stop_b);
        if (extra_low > 0) wait_ticks(extra_low);
        @(negedge clk);
        rxd = 1'b1;
        wait_ticks(6);
    endtask

    // Send a frame and compare the result with the expected values
    task automatic frame_test(input logic [7:0] lcr, input logic [7:0] data,
                              input bit bad_par, input logic stop_b, input int extra_low,
                              input bit chg, input logic [7:0] lcr2, input string tag);
        int len;
        logic [7:0] d;
        logic p, e_perr, e_brk;
        len = 5 + lcr[1:0];
        d = data & ((8'd1 << len) - 8'd1);
        if (lcr[5]) p = ~lcr[4];
        else        p = lcr[4] ? ^d : ~^d;
        p = p ^ bad_par;
        e_perr = lcr[3] & bad_par;
        e_brk  = (d == 8'd0) && (!lcr[3] || !p) && !stop_b;
        valid_cnt = 0;
        send_frame(lcr, data, bad_par, stop_b, extra_low, chg, lcr2);
        check(valid_cnt == 1, {tag, " R10 strobe count"}, valid_cnt, 1);
        check(cap_data == d, {tag, " R2 data"}, cap_data, d);
        check(cap_perr == e_perr,
              {tag, lcr[3] ? (lcr[5] ? " R5 stick parity" : " R4 parity") : " R6 no parity"},
              cap_perr, e_perr);
        check(cap_ferr == !stop_b, {tag, " R7 framing"}, cap_ferr, !stop_b);
        check(cap_brk == e_brk, {tag, " R8 break"}, cap_brk, e_brk);
        check(rx_data == d, {tag, " R10 held data"}, rx_data, d);
    endtask

    initial begin
        repeat (2000000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] pats [4];
        pats[0] = 8'hA5; pats[1] = 8'h00; pats[2] = 8'hFF; pats[3] = 8'h3C;
        repeat (5) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(!rx_valid && rx_data == 0 && !parity_err && !frame_err && !break_det,
              "R11 reset", {rx_valid, rx_data, parity_err, frame_err, break_det}, 0);

        // R2 R4 R5 R6 R7: sweep all low control combinations and patterns
        for (int l = 0; l < 64; l++)
            for (int di = 0; di < 4; di++)
                frame_test(8'(l) | 8'hC0 & 8'(l << 2), pats[di], di[0], 1'b1, 0, 1'b0, 8'h0, "sweep");

        // R8: all-zero frames with a low stop bit in every setting
        for (int l = 0; l < 64; l++)
            frame_test(8'(l), 8'h00, 1'b0, 1'b0, 0, 1'b0, 8'h0, "zero");

        // R7: framing error without break
        for (int l = 0; l < 8; l++)
            frame_test(8'(l * 5), 8'h5A, 1'b0, 1'b0, 0, 1'b0, 8'h0, "frame");

        // R9: line held low long after a bad stop bit, then a good frame
        frame_test(8'h03, 8'h00, 1'b0, 1'b0, 70, 1'b0, 8'h0, "R9 long low");
        frame_test(8'h1B, 8'h96, 1'b0, 1'b1, 0, 1'b0, 8'h0, "R9 recovery");

        // R1: start glitch shorter than half a bit
        valid_cnt = 0;
        @(negedge clk) rxd = 1'b0;
        wait_ticks(4);
        @(negedge clk) rxd = 1'b1;
        wait_ticks(40);
        check(valid_cnt == 0, "R1 glitch rejected", valid_cnt, 0);
        frame_test(8'h0B, 8'h6E, 1'b0, 1'b1, 0, 1'b0, 8'h0, "R1 after glitch");

        // R12: control change mid-frame does not alter this frame
        frame_test(8'h1B, 8'hC3, 1'b0, 1'b1, 0, 1'b1, 8'h08, "R12 change");
        frame_test(8'h3A, 8'h55, 1'b1, 1'b1, 0, 1'b1, 8'h03, "R12 change2");

        // R3: slower, gated tick
        tick_div = 3;
        for (int k = 0; k < 6; k++)
            frame_test(8'(8'h08 + k * 9), 8'(8'h5B + k * 37), k[0], 1'b1, 0, 1'b0, 8'h0, "R3 gated");
        tick_div = 1;

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule